// File: doc/BRIEF.md
# I/O Port Address Decoder

This block turns an access to a 16-bit I/O port space into a physical request target. Every request presents a port number, an access size in bytes, a direction and write data. One cycle later the block answers with the physical address the access should go to, or with a flag that says the access was consumed internally, found no target, or carried an illegal port number.

The block holds one 32-bit configuration-address register. A 4-byte access to port 0xCF8 reads or writes this register. Ports 0xCFC to 0xCFF form a four-byte data window. When bit 31 of the register is set, an access to the window is steered into a configuration physical region. The address in that region is built from register bits 30..2 and the low two port bits. When bit 31 is clear, a window access has no target. Every other legal port maps linearly into an I/O physical region.

Both region bases are parameters that sit above bit 32, so they never collide with the port or register fields.

Top module: `iodec_top`

## Requirements
- R1: After reset, no response is valid and the configuration-address register holds zero, so a 4-byte read of port 0xCF8 returns 0.
- R2: Each accepted request (req_valid high at a clock edge) produces exactly one response with rsp_valid high on the following edge, and rsp_valid is low on every other edge.
- R3: A request whose port input has any bit above bit 15 set returns rsp_range_err=1 with address 0 and the other flags clear, and leaves the register unchanged.
- R4: A 4-byte write to port 0xCF8 loads the register with the write data and returns rsp_reg_hit=1 with address 0. No other request changes the register.
- R5: A 4-byte read of port 0xCF8 returns rsp_reg_hit=1, address 0, and the register value on rsp_rdata.
- R6: An access to port 0xCF8 with a size other than 4 bytes is an ordinary I/O access to IO_BASE | 0xCF8 and leaves the register unchanged.
- R7: An access to a port in the range 0xCFC to 0xCFF while register bit 31 is 1 returns CFG_BASE | {register[30:2], port[1:0]}. Register bits 1..0 do not reach the address.
- R8: An access to a port in the range 0xCFC to 0xCFF while register bit 31 is 0 returns rsp_unmapped=1 with address 0. A read returns all ones on rsp_rdata, and a write has no effect on any state.
- R9: Every other port below 0x10000 returns IO_BASE | port with all flags clear.
- R10: A register write takes effect for a request accepted on the very next edge.
- R11: rsp_rdata is zero on every response except the reads described in R5 and R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_port | input | 32 | Port number; bits above 15 must be zero |
| req_size | input | 3 | Access size in bytes (1, 2 or 4) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_addr | output | 48 | Physical target address |
| rsp_reg_hit | output | 1 | Access consumed by the configuration-address register |
| rsp_unmapped | output | 1 | Data-window access while disabled |
| rsp_range_err | output | 1 | Port number out of 16-bit range |
| rsp_rdata | output | 32 | Read data for register reads and unmapped reads |

## Verification
Two functions can fall into the same clock edge. The first is the register update from a write to 0xCF8. The second is the decode of the next request, which uses that register. The bench issues a register write and a data-window access on consecutive edges with no idle cycle between them. It does this once to enable the window and once to disable it. The response to the window access must show the new register contents: the steered address in the first case, and the unmapped flag with all-ones read data in the second. An out-of-range write and a 1-byte write to 0xCF8 are followed immediately by a register read, which must return the old value.

// File: rtl/iodec_pkg.sv
package iodec_pkg;

    localparam int PORT_IN_W = 32;
    localparam int PORT_W    = 16;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 48;
    localparam int SIZE_W    = 3;
    localparam int EN_BIT    = 31;

    localparam logic [PORT_W-1:0] CFG_ADDR_PORT = 16'h0CF8;
    localparam logic [PORT_W-1:0] CFG_DATA_PORT = 16'h0CFC;
    localparam logic [SIZE_W-1:0] DWORD_SIZE    = 3'd4;

    typedef enum logic [2:0] {
        K_IO       = 3'd0,
        K_CFG_REG  = 3'd1,
        K_CFG_DATA = 3'd2,
        K_CFG_OFF  = 3'd3,
        K_RANGE    = 3'd4
    } kind_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              reg_hit;
        logic              unmapped;
        logic              range_err;
        logic [DATA_W-1:0] rdata;
    } rsp_t;

    function automatic logic in_data_window(input logic [PORT_W-1:0] p);
        return p[PORT_W-1:2] == CFG_DATA_PORT[PORT_W-1:2];
    endfunction

endpackage

// File: rtl/iodec_classify.sv
module iodec_classify
    import iodec_pkg::*;
(
    input  logic                 valid,
    input  logic [PORT_IN_W-1:0] port_in,
    input  logic [SIZE_W-1:0]    size,
    input  logic                 write,
    input  logic                 cfg_en,
    output kind_e                kind,
    output logic                 reg_wr
);
    logic              hi_bits;
    logic [PORT_W-1:0] p;

    always_comb begin
        hi_bits = |port_in[PORT_IN_W-1:PORT_W];
        p       = port_in[PORT_W-1:0];
        if (hi_bits)
            kind = K_RANGE;
        else if (p == CFG_ADDR_PORT && size == DWORD_SIZE)
            kind = K_CFG_REG;
        else if (in_data_window(p))
            kind = cfg_en ? K_CFG_DATA : K_CFG_OFF;
        else
            kind = K_IO;
        reg_wr = valid && write && (kind == K_CFG_REG);
    end
endmodule

// File: rtl/iodec_cfg_reg.sv
module iodec_cfg_reg
    import iodec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (wr_en)
            q <= wdata;
    end
endmodule

// File: rtl/iodec_addr_gen.sv
module iodec_addr_gen
    import iodec_pkg::*;
#(
    parameter logic [ADDR_W-1:0] IO_BASE  = 48'h0001_0000_0000,
    parameter logic [ADDR_W-1:0] CFG_BASE = 48'h0002_0000_0000
) (
    input  kind_e             kind,
    input  logic [PORT_W-1:0] port,
    input  logic              write,
    input  logic [DATA_W-1:0] cfg_q,
    output rsp_t              rsp
);
    always_comb begin
        rsp = '0;
        unique case (kind)
            K_IO:       rsp.addr = IO_BASE | ADDR_W'(port);
            K_CFG_DATA: rsp.addr = CFG_BASE | ADDR_W'({cfg_q[EN_BIT-1:2], port[1:0]});
            K_CFG_REG: begin
                rsp.reg_hit = 1'b1;
                rsp.rdata   = write ? '0 : cfg_q;
            end
            K_CFG_OFF: begin
                rsp.unmapped = 1'b1;
                rsp.rdata    = write ? '0 : '1;
            end
            default:    rsp.range_err = 1'b1;
        endcase
    end
endmodule

// File: rtl/iodec_top.sv
module iodec_top
    import iodec_pkg::*;
#(
    parameter logic [ADDR_W-1:0] IO_BASE  = 48'h0001_0000_0000,
    parameter logic [ADDR_W-1:0] CFG_BASE = 48'h0002_0000_0000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [PORT_IN_W-1:0] req_port,
    input  logic [SIZE_W-1:0]    req_size,
    input  logic                 req_write,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 rsp_valid,
    output logic [ADDR_W-1:0]    rsp_addr,
    output logic                 rsp_reg_hit,
    output logic                 rsp_unmapped,
    output logic                 rsp_range_err,
    output logic [DATA_W-1:0]    rsp_rdata
);
    kind_e             kind;
    logic              reg_wr;
    logic [DATA_W-1:0] cfg_q;
    rsp_t              rsp_d;
    rsp_t              rsp_q;
    logic              vld_q;

    iodec_classify u_classify (
        .valid   (req_valid),
        .port_in (req_port),
        .size    (req_size),
        .write   (req_write),
        .cfg_en  (cfg_q[EN_BIT]),
        .kind    (kind),
        .reg_wr  (reg_wr)
    );

    iodec_cfg_reg u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr_en (reg_wr),
        .wdata (req_wdata),
        .q     (cfg_q)
    );

    iodec_addr_gen #(
        .IO_BASE  (IO_BASE),
        .CFG_BASE (CFG_BASE)
    ) u_addr (
        .kind  (kind),
        .port  (req_port[PORT_W-1:0]),
        .write (req_write),
        .cfg_q (cfg_q),
        .rsp   (rsp_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            rsp_q <= '0;
        end else begin
            vld_q <= req_valid;
            rsp_q <= req_valid ? rsp_d : '0;
        end
    end

    assign rsp_valid     = vld_q;
    assign rsp_addr      = rsp_q.addr;
    assign rsp_reg_hit   = rsp_q.reg_hit;
    assign rsp_unmapped  = rsp_q.unmapped;
    assign rsp_range_err = rsp_q.range_err;
    assign rsp_rdata     = rsp_q.rdata;
endmodule

// File: rtl/iodec_checker.sv
module iodec_checker
    import iodec_pkg::*;
#(
    parameter logic [ADDR_W-1:0] IO_BASE  = 48'h0001_0000_0000,
    parameter logic [ADDR_W-1:0] CFG_BASE = 48'h0002_0000_0000
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic [PORT_IN_W-1:0] req_port,
    input logic [SIZE_W-1:0]    req_size,
    input logic                 req_write,
    input logic                 rsp_valid,
    input logic [ADDR_W-1:0]    rsp_addr,
    input logic                 rsp_reg_hit,
    input logic                 rsp_unmapped,
    input logic                 rsp_range_err,
    input logic [DATA_W-1:0]    cfg_q
);
    assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $onehot0({rsp_reg_hit, rsp_unmapped, rsp_range_err}));

    assert_range_err_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (|req_port[PORT_IN_W-1:PORT_W]))
        |=> (rsp_range_err && rsp_addr == '0));

    assert_reg_only_by_write_R4: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_write && req_size == DWORD_SIZE
          && req_port == PORT_IN_W'(CFG_ADDR_PORT))
        |=> $stable(cfg_q));

    assert_cfg_steer_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !(|req_port[PORT_IN_W-1:PORT_W])
         && in_data_window(req_port[PORT_W-1:0]) && cfg_q[EN_BIT])
        |=> (rsp_addr == (CFG_BASE | ADDR_W'({$past(cfg_q[EN_BIT-1:2]), $past(req_port[1:0])}))));

    assert_unmapped_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !(|req_port[PORT_IN_W-1:PORT_W])
         && in_data_window(req_port[PORT_W-1:0]) && !cfg_q[EN_BIT])
        |=> (rsp_unmapped && rsp_addr == '0));

    assert_io_linear_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !(|req_port[PORT_IN_W-1:PORT_W])
         && !in_data_window(req_port[PORT_W-1:0])
         && req_port[PORT_W-1:0] != CFG_ADDR_PORT)
        |=> (rsp_addr == (IO_BASE | ADDR_W'($past(req_port[PORT_W-1:0])))));
endmodule

bind iodec_top iodec_checker #(
    .IO_BASE  (IO_BASE),
    .CFG_BASE (CFG_BASE)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_port      (req_port),
    .req_size      (req_size),
    .req_write     (req_write),
    .rsp_valid     (rsp_valid),
    .rsp_addr      (rsp_addr),
    .rsp_reg_hit   (rsp_reg_hit),
    .rsp_unmapped  (rsp_unmapped),
    .rsp_range_err (rsp_range_err),
    .cfg_q         (cfg_q)
);

// File: tb/iodec_top_bench.sv
`timescale 1ns/1ps
module iodec_top_bench;

    localparam logic [47:0] IO_B  = 48'h0001_0000_0000;
    localparam logic [47:0] CFG_B = 48'h0002_0000_0000;

    typedef struct packed {
        logic [47:0] addr;
        logic        reg_hit;
        logic        unmapped;
        logic        range_err;
        logic [31:0] rdata;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_port  = '0;
    logic [2:0]  req_size  = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [47:0] rsp_addr;
    logic        rsp_reg_hit;
    logic        rsp_unmapped;
    logic        rsp_range_err;
    logic [31:0] rsp_rdata;

    int errors = 0;
    int checks = 0;
    logic [31:0] model_cfg = '0;
    exp_t  expq[$];
    string tagq[$];

    always #2 clk = ~clk;

    iodec_top u_iodec_top (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_port      (req_port),
        .req_size      (req_size),
        .req_write     (req_write),
        .req_wdata     (req_wdata),
        .rsp_valid     (rsp_valid),
        .rsp_addr      (rsp_addr),
        .rsp_reg_hit   (rsp_reg_hit),
        .rsp_unmapped  (rsp_unmapped),
        .rsp_range_err (rsp_range_err),
        .rsp_rdata     (rsp_rdata)
    );

    function automatic exp_t predict(input logic [31:0] port, input logic [2:0] size,
                                     input logic wr, input logic [31:0] wd);
        exp_t e = '0;
        if (port[31:16] != 0) begin
            e.range_err = 1'b1;
        end else if (port[15:0] == 16'h0CF8 && size == 3'd4) begin
            e.reg_hit = 1'b1;
            e.rdata   = wr ? 32'h0 : model_cfg;
            if (wr) model_cfg = wd;
        end else if (port[15:2] == 14'h033F) begin
            if (model_cfg[31]) begin
                e.addr = CFG_B | {17'h0, model_cfg[30:2], port[1:0]};
            end else begin
                e.unmapped = 1'b1;
                e.rdata    = wr ? 32'h0 : 32'hFFFF_FFFF;
            end
        end else begin
            e.addr = IO_B | {32'h0, port[15:0]};
        end
        return e;
    endfunction

    task automatic drive(input string tag, input logic [31:0] port, input logic [2:0] size,
                         input logic wr, input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1;
        req_port  = port;
        req_size  = size;
        req_write = wr;
        req_wdata = wd;
        expq.push_back(predict(port, size, wr, wd));
        tagq.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    task automatic check(input string tag, input logic ok, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            exp_t  e;
            exp_t  a;
            string t;
            a = {rsp_addr, rsp_reg_hit, rsp_unmapped, rsp_range_err, rsp_rdata};
            if (expq.size() == 0) begin
                check("R2 unexpected response", 1'b0, 128'(a), 128'h0);
            end else begin
                e = expq.pop_front();
                t = tagq.pop_front();
                check(t, a == e, 128'(a), 128'(e));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 no response in reset", rsp_valid == 1'b0, 128'(rsp_valid), 128'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 no response after reset", rsp_valid == 1'b0, 128'(rsp_valid), 128'h0);

        drive("R1 R5 register reads zero", 32'h0CF8, 3'd4, 1'b0, 32'h0);
        drive("R9 byte port 0x60", 32'h0060, 3'd1, 1'b0, 32'h0);
        drive("R9 top port 0xFFFF", 32'hFFFF, 3'd2, 1'b1, 32'hAB);
        drive("R8 R11 window read disabled", 32'h0CFC, 3'd4, 1'b0, 32'h0);
        drive("R8 R11 window write disabled", 32'h0CFE, 3'd1, 1'b1, 32'h5555_AAAA);
        drive("R8 state untouched by dropped write", 32'h0CF8, 3'd4, 1'b0, 32'h0);
        drive("R6 word access to 0xCF8", 32'h0CF8, 3'd2, 1'b0, 32'h0);
        drive("R6 byte write to 0xCF8", 32'h0CF8, 3'd1, 1'b1, 32'h8000_0000);
        drive("R6 register unchanged", 32'h0CF8, 3'd4, 1'b0, 32'h0);
        idle();
        @(negedge clk);
        check("R2 idle gives no response", rsp_valid == 1'b0, 128'(rsp_valid), 128'h0);

        drive("R4 register write", 32'h0CF8, 3'd4, 1'b1, 32'h8001_2347);
        drive("R7 R10 window steered next cycle", 32'h0CFD, 3'd1, 1'b0, 32'h0);
        drive("R5 register readback", 32'h0CF8, 3'd4, 1'b0, 32'h0);
        drive("R7 R11 window write last byte", 32'h0CFF, 3'd1, 1'b1, 32'h77);
        drive("R3 out of range write", 32'h0001_0CF8, 3'd4, 1'b1, 32'h0);
        drive("R3 register kept", 32'h0CF8, 3'd4, 1'b0, 32'h0);
        drive("R3 high bit port", 32'h8000_0060, 3'd1, 1'b0, 32'h0);
        drive("R9 port below window", 32'h0CFB, 3'd1, 1'b0, 32'h0);
        drive("R9 port above window", 32'h0D00, 3'd4, 1'b0, 32'h0);
        drive("R4 R10 register disable", 32'h0CF8, 3'd4, 1'b1, 32'h0000_1234);
        drive("R8 R10 window off next cycle", 32'h0CFC, 3'd2, 1'b0, 32'h0);
        drive("R4 R7 reenable", 32'h0CF8, 3'd4, 1'b1, 32'hFFFF_FFFF);
        drive("R7 all bits steered", 32'h0CFE, 3'd2, 1'b1, 32'h0);
        idle();
        repeat (3) @(negedge clk);
        check("R2 every request answered", expq.size() == 0, 128'(expq.size()), 128'h0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule